// File: doc/BRIEF.md
# Watchdog Counter with Sign-Bit Grace Period

This block guards against software that stops running its main loop. It holds an 8-bit down counter with an extra sign bit above it. The count loads to its full value (255) out of reset and steps down by one on each slow tick. The tick has a nominal period of 10.24 ms, which gives a longest timeout of roughly 2.6 s. The tick comes from outside the block and is seen here as a one-cycle enable. Software keeps the system alive by writing a fresh count through a guarded write port. A write takes effect only when the guard field above the count bits is all zeros, so a runaway routine that writes all ones cannot reload the counter.

When the counter runs out, one of two outcomes follows, chosen by a mode input. In interrupt-first mode, a sticky non-maskable interrupt is raised when the count reaches zero. The sign bit then lets the count continue into negative values, and a system reset pulse is issued at minus 16 if software still has not reloaded it. In reset-only mode, the reset pulse is issued as soon as the count reaches zero. A freeze input from a debugger halts the count. The reset pulse lasts one cycle, after which the counter reloads itself to 255.

Top module: `wdog_signed_grace`

## Requirements
- R1: After the synchronous reset input, `rd_value` reads 0x0FF, and `nmi_o` and `rst_o` are both low.
- R2: A cycle with `tick_en` high and `freeze` low, and with no accepted write and no reset pulse, lowers the 9-bit two's complement value on `rd_value` by one from the next cycle onward.
- R3: While `freeze` is high the count ignores `tick_en` and keeps its value.
- R4: A write with `wr_en` high and `wr_data[12:8]` all zero loads `{1'b0, wr_data[7:0]}` on the next edge and clears `nmi_o`. This holds while frozen too.
- R5: A write whose `wr_data[12:8]` has any bit set changes neither the count nor `nmi_o`.
- R6: With `nmi_mode` high, the edge at which a tick brings the value to zero or below sets `nmi_o`. It stays high until an accepted write or a reset pulse.
- R7: With `nmi_mode` high, the count keeps going below zero with bit 8 of `rd_value` set. The tick that brings it to -16 (0x1F0) raises `rst_o` on the same edge.
- R8: With `nmi_mode` low, the tick that brings the value to zero or below raises `rst_o`, and `nmi_o` is never set.
- R9: `rst_o` is high for exactly one cycle. In the cycle after it, `rd_value` is 0x0FF and `nmi_o` is low, and ticks and writes in the pulse cycle are discarded.
- R10: When an accepted write and a tick arrive in the same cycle, the write wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle slow tick strobe |
| wr_en | input | 1 | Reload write strobe |
| wr_data | input | 13 | Bits 12:8 are the guard field, bits 7:0 the new count |
| nmi_mode | input | 1 | 1: interrupt then reset; 0: reset at zero |
| freeze | input | 1 | Debugger halt of the count |
| rd_value | output | 9 | Current value, sign in bit 8, two's complement |
| nmi_o | output | 1 | Sticky non-maskable interrupt |
| rst_o | output | 1 | One-cycle system reset pulse |

## Verification
The assertions assume that `tick_en`, `wr_en`, `wr_data`, `freeze` and `nmi_mode` are synchronous to `clk` and stable around each edge. They also assume that the reset input is held for at least one edge before anything is checked. The stimulus changes every input only on the falling edge.

The stimulus also keeps the grace depth far below the count range, so the value never wraps past its negative limit. It covers mode changes only between whole runs. Even so, a mode change while the value is already negative still ends in a reset pulse at the next tick.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic {
        MODE_RESET_ONLY = 1'b0,
        MODE_NMI_FIRST  = 1'b1
    } wdg_mode_e;

    typedef struct packed {
        logic       accept;
        logic [7:0] load;
    } wdg_load_t;

    function automatic logic guard_clear(input logic [4:0] guard);
        return guard == '0;
    endfunction

endpackage

// File: rtl/wdg_write_guard.sv
module wdg_write_guard #(
    parameter int CNT_W   = 8,
    parameter int GUARD_W = 5,
    localparam int WDATA_W = CNT_W + GUARD_W
) (
    input  logic               wr_en,
    input  logic [WDATA_W-1:0] wr_data,
    output logic               load_ok,
    output logic [CNT_W-1:0]   load_val
);
    logic [GUARD_W-1:0] guard_bits;

    always_comb begin
        guard_bits = wr_data[WDATA_W-1:CNT_W];
        load_val   = wr_data[CNT_W-1:0];
        load_ok    = wr_en && (guard_bits == '0);
    end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int GRACE = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_en,
    input  logic                    freeze,
    input  wdg_mode_e               mode,
    input  logic                    load_ok,
    input  logic [CNT_W-1:0]        load_val,
    output logic signed [CNT_W:0]   value,
    output logic                    lands_nonpos,
    output logic                    bite
);
    localparam logic signed [CNT_W:0] FULL    = {1'b0, {CNT_W{1'b1}}};
    localparam logic signed [CNT_W:0] ZERO    = '0;
    localparam logic signed [CNT_W:0] ONE     = {{CNT_W{1'b0}}, 1'b1};
    localparam logic signed [CNT_W:0] LIM_NMI = (CNT_W+1)'(-GRACE);

    logic                  stepping;
    logic signed [CNT_W:0] dec;
    logic signed [CNT_W:0] limit;
    logic                  bite_d;

    always_comb begin
        stepping     = tick_en && !freeze && !bite && !load_ok;
        dec          = value - ONE;
        limit        = (mode == MODE_NMI_FIRST) ? LIM_NMI : ZERO;
        lands_nonpos = stepping && (dec <= ZERO);
        bite_d       = stepping && (dec <= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= FULL;
            bite  <= 1'b0;
        end else begin
            bite <= bite_d;
            if (bite)
                value <= FULL;
            else if (load_ok)
                value <= {1'b0, load_val};
            else if (stepping)
                value <= dec;
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        bite |=> !bite);
    a_r9_reload_full: assert property (@(posedge clk) disable iff (rst)
        bite |=> value == FULL);
    a_r3_freeze_hold: assert property (@(posedge clk) disable iff (rst)
        freeze && !load_ok && !bite |=> $stable(value));
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        tick_en && !freeze && !load_ok && !bite |=> value == $past(value) - ONE);
    a_r4_load_value: assert property (@(posedge clk) disable iff (rst)
        load_ok && !bite |=> value == {1'b0, $past(load_val)});

endmodule

// File: rtl/wdg_outcome.sv
module wdg_outcome
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wdg_mode_e mode,
    input  logic      lands_nonpos,
    input  logic      load_ok,
    input  logic      bite,
    output logic      nmi
);
    always_ff @(posedge clk) begin
        if (rst)
            nmi <= 1'b0;
        else if (bite || load_ok)
            nmi <= 1'b0;
        else if (lands_nonpos && mode == MODE_NMI_FIRST)
            nmi <= 1'b1;
    end

    a_r8_nmi_needs_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi) |-> $past(mode) == MODE_NMI_FIRST);
    a_r4_load_clears_nmi: assert property (@(posedge clk) disable iff (rst)
        load_ok |=> !nmi);
    a_r6_nmi_sticky: assert property (@(posedge clk) disable iff (rst)
        nmi && !load_ok && !bite |=> nmi);

endmodule

// File: rtl/wdog_signed_grace.sv
module wdog_signed_grace
    import wdg_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int GUARD_W = 5,
    parameter int GRACE   = 16,
    localparam int WDATA_W = CNT_W + GUARD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic               wr_en,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               nmi_mode,
    input  logic               freeze,
    output logic [CNT_W:0]     rd_value,
    output logic               nmi_o,
    output logic               rst_o
);
    wdg_mode_e             mode;
    logic                  load_ok;
    logic [CNT_W-1:0]      load_val;
    logic signed [CNT_W:0] value;
    logic                  lands_nonpos;
    logic                  bite;

    assign mode = wdg_mode_e'(nmi_mode);

    wdg_write_guard #(.CNT_W(CNT_W), .GUARD_W(GUARD_W)) u_guard (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .load_ok  (load_ok),
        .load_val (load_val)
    );

    wdg_counter #(.CNT_W(CNT_W), .GRACE(GRACE)) u_count (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .freeze       (freeze),
        .mode         (mode),
        .load_ok      (load_ok),
        .load_val     (load_val),
        .value        (value),
        .lands_nonpos (lands_nonpos),
        .bite         (bite)
    );

    wdg_outcome u_outcome (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .lands_nonpos (lands_nonpos),
        .load_ok      (load_ok),
        .bite         (bite),
        .nmi          (nmi_o)
    );

    assign rd_value = value;
    assign rst_o    = bite;

    a_r5_guard_reject: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_data[WDATA_W-1:CNT_W] != '0) && !tick_en && !rst_o
        |=> $stable(rd_value) && $stable(nmi_o));

endmodule

// File: tb/wdog_signed_grace_tb.sv
module wdog_signed_grace_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [12:0] wr_data = '0;
    logic        nmi_mode = 1'b0;
    logic        freeze = 1'b0;
    logic [8:0]  rd_value;
    logic        nmi_o;
    logic        rst_o;

    always #5 clk = ~clk;

    wdog_signed_grace u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_data(wr_data), .nmi_mode(nmi_mode), .freeze(freeze),
        .rd_value(rd_value), .nmi_o(nmi_o), .rst_o(rst_o)
    );

    int    compared = 0;
    int    mismatched = 0;
    int    pulses = 0;
    bit    armed = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference
    int mval = 255;
    bit mnmi = 0;
    bit mbite = 0;

    always @(posedge clk) begin
        bit nb;
        nb = 0;
        if (rst) begin
            mval = 255; mnmi = 0; mbite = 0; armed = 1;
        end else begin
            if (mbite) begin
                mval = 255; mnmi = 0;
            end else if (wr_en && wr_data[12:8] == 5'd0) begin
                mval = int'(wr_data[7:0]); mnmi = 0;
            end else if (tick_en && !freeze) begin
                mval = mval - 1;
                if (mval <= 0 && nmi_mode) mnmi = 1;
                if (mval <= (nmi_mode ? -16 : 0)) nb = 1;
            end
            mbite = nb;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            logic [8:0] ev;
            ev = 9'(mval);
            check(rd_value == ev, cur_req, "rd_value", int'(rd_value), int'(ev));
            check(nmi_o == mnmi, cur_req, "nmi_o", int'(nmi_o), int'(mnmi));
            check(rst_o == mbite, cur_req, "rst_o", int'(rst_o), int'(mbite));
            if (rst_o) pulses++;
        end
    end

    task automatic drive(input bit t, input bit w, input logic [12:0] d, input bit f);
        @(negedge clk);
        tick_en = t; wr_en = w; wr_data = d; freeze = f;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, '0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: run hung, actual 0 expected 1 completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        rst = 0;
        idle(3);

        cur_req = "R2";
        for (int i = 0; i < 10; i++) begin drive(1, 0, '0, 0); drive(0, 0, '0, 0); end

        cur_req = "R3";
        for (int i = 0; i < 6; i++) drive(1, 0, '0, 1);
        idle(2);

        cur_req = "R4";
        drive(0, 1, 13'h0020, 0);
        drive(0, 1, 13'h0077, 1);
        idle(2);

        cur_req = "R5";
        for (int b = 8; b < 13; b++) drive(0, 1, 13'(1 << b) | 13'h0011, 0);
        drive(0, 1, 13'h1FFF, 0);
        idle(2);

        cur_req = "R6";
        nmi_mode = 1;
        drive(0, 1, 13'h0005, 0);
        for (int i = 0; i < 7; i++) drive(1, 0, '0, 0);
        drive(0, 1, 13'h1F40, 0);
        idle(2);
        drive(0, 1, 13'h0002, 0);
        for (int i = 0; i < 3; i++) drive(1, 0, '0, 0);

        cur_req = "R7";
        p0 = pulses;
        for (int i = 0; i < 20; i++) drive(1, 0, '0, 0);
        cur_req = "R9";
        drive(0, 1, 13'h0003, 0);
        idle(3);
        check(pulses - p0 == 1, "R7", "pulse count", pulses - p0, 1);

        cur_req = "R8";
        nmi_mode = 0;
        drive(0, 1, 13'h0003, 0);
        p0 = pulses;
        for (int i = 0; i < 6; i++) drive(1, 0, '0, 0);
        idle(2);
        check(pulses - p0 == 1, "R8", "pulse count", pulses - p0, 1);

        cur_req = "R10";
        drive(1, 1, 13'h0040, 0);
        drive(1, 1, 13'h0041, 0);
        drive(1, 1, 13'h1041, 0);
        idle(2);

        cur_req = "R9";
        nmi_mode = 1;
        drive(0, 0, '0, 0);
        rst = 1; idle(1); rst = 0;
        p0 = pulses;
        for (int i = 0; i < 275; i++) drive(1, 0, '0, 0);
        idle(3);
        check(pulses - p0 == 1, "R9", "pulse count full run", pulses - p0, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule